// File: doc/BRIEF.md
# Vectored Dual-Output Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and drives two request outputs. One output is for the fast class and one is for the normal class. Each source keeps three bits: a pending flag, an enable flag and a class flag. A class flag of 1 puts the source in the fast class. Each source also has a 4-bit priority. Normal requests must clear a programmable threshold level before they reach the normal output. When the threshold is at its all-ones value, this filter is bypassed.

Software uses a 32-bit word-addressed register bus. A read completes in the same cycle. A write takes effect at the next clock edge. Reading one of the two vector registers returns the lowest-numbered pending, enabled source of that class, and the same read acknowledges that source by clearing its pending flag.

The bus carries register accesses, not a data stream, so it has no valid/ready handshake and no back-pressure. The block accepts every access in the cycle it is presented. A read and a write may be presented together, and both take effect.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the level register reads 0x1F. The enable, class, pending, priority and control registers read 0. Both outputs are low, and both vector registers read 0xFFFF0000.
- R2: A rising input line sets that source's pending flag and a falling line clears it, at the same clock edge that samples the change. Word 18 reads pending bits 63..32 and word 19 reads bits 31..0.
- R3: The registered output `fast_irq` is high one cycle after any source is pending, enabled and of class fast (class bit 1), and is low otherwise.
- R4: With the level register at 0x1F, `normal_irq` is high one cycle after any source is pending, enabled and of class normal (class bit 0), and is low otherwise.
- R5: With the level register below 0x1F, `normal_irq` is high one cycle after at least one pending, enabled, normal source has a priority strictly greater than the level. It is low otherwise and never holds a stale high.
- R6: The level register (word 1) stores bits 4:0 only, and bits 31:5 read as 0.
- R7: Writing an index below 64 to word 2 sets that one enable bit, and writing it to word 3 clears it. An index of 64 or more is ignored, and both words read as 0. Words 4 and 5 hold enable bits 63..32 and 31..0. Words 6 and 7 hold class bits 63..32 and 31..0.
- R8: The priority of source n sits in bits 4*(n mod 8)+3 .. 4*(n mod 8) of word 15 - floor(n/8). Word 15 therefore covers sources 0..7 and word 8 covers sources 56..63.
- R9: Reading word 16 (normal) or word 17 (fast) returns the lowest-numbered pending, enabled source of that class in bits 31:16, with bits 15:0 zero. The same read clears that source's pending flag at the edge, and this clear overrides an input edge or a force write in that cycle. With no such source the read returns 0xFFFF0000.
- R10: A write to word 20 replaces pending bits 63..32, and a write to word 21 replaces bits 31..0. This replacement overrides input edges on those bits in the same cycle. Both words read as 0.
- R11: Words 22 and 23 read the pending, enabled, normal bits (upper half, then lower half). Words 24 and 25 read the pending, enabled, fast bits in the same order.
- R12: Writes to words 16..19, 22..25 and 0x40..0xBF change nothing. A read of word 0x40 returns 4. Words not listed elsewhere read 0 and ignore writes.
- R13: Word 0 is a 32-bit control register that stores and returns any value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 64 | Interrupt source lines, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects of vector reads apply at the edge |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| fast_irq | output | 1 | Registered fast-class request |
| normal_irq | output | 1 | Registered, priority-filtered normal-class request |

## Verification
The hardest state to reach is one where several normal sources are pending and enabled with a mix of priorities on both sides of the level. In that state an acknowledge removes the only source above the threshold, and the output must drop while other sources remain pending. The random phase reaches it by keeping the level mostly within the 0..15 range and by rewriting priority words often. It also enables sources by index, toggles lines and issues vector reads. Every read value and both outputs are compared each cycle against a bench model built from the requirements.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned SRC_COUNT = 64;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned WADDR_W   = 10;
  localparam int unsigned PRI_W     = 4;
  localparam int unsigned LVL_W     = 5;

  localparam logic [WADDR_W-1:0] OFS_CTRL      = 10'd0;
  localparam logic [WADDR_W-1:0] OFS_LEVEL     = 10'd1;
  localparam logic [WADDR_W-1:0] OFS_EN_SET    = 10'd2;
  localparam logic [WADDR_W-1:0] OFS_EN_CLR    = 10'd3;
  localparam logic [WADDR_W-1:0] OFS_EN_HI     = 10'd4;
  localparam logic [WADDR_W-1:0] OFS_EN_LO     = 10'd5;
  localparam logic [WADDR_W-1:0] OFS_TYPE_HI   = 10'd6;
  localparam logic [WADDR_W-1:0] OFS_TYPE_LO   = 10'd7;
  localparam logic [WADDR_W-1:0] OFS_PRI_FIRST = 10'd8;
  localparam logic [WADDR_W-1:0] OFS_PRI_LAST  = 10'd15;
  localparam logic [WADDR_W-1:0] OFS_VEC_NORM  = 10'd16;
  localparam logic [WADDR_W-1:0] OFS_VEC_FAST  = 10'd17;
  localparam logic [WADDR_W-1:0] OFS_RAW_HI    = 10'd18;
  localparam logic [WADDR_W-1:0] OFS_RAW_LO    = 10'd19;
  localparam logic [WADDR_W-1:0] OFS_FORCE_HI  = 10'd20;
  localparam logic [WADDR_W-1:0] OFS_FORCE_LO  = 10'd21;
  localparam logic [WADDR_W-1:0] OFS_NPEND_HI  = 10'd22;
  localparam logic [WADDR_W-1:0] OFS_NPEND_LO  = 10'd23;
  localparam logic [WADDR_W-1:0] OFS_FPEND_HI  = 10'd24;
  localparam logic [WADDR_W-1:0] OFS_FPEND_LO  = 10'd25;
  localparam logic [WADDR_W-1:0] OFS_TBL_FIRST = 10'h040;
  localparam logic [WADDR_W-1:0] OFS_TBL_LAST  = 10'h0BF;

  localparam logic [BUS_W-1:0] IDLE_MARKER = 32'd4;
  localparam logic [BUS_W-1:0] NO_VECTOR   = 32'hFFFF_0000;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] force_mask_i,
  input  logic [N-1:0] force_val_i,
  input  logic [N-1:0] ack_mask_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] line_q;
  logic [N-1:0] rise;
  logic [N-1:0] fall;
  logic [N-1:0] pend_d;

  assign rise = line_i & ~line_q;
  assign fall = ~line_i & line_q;

  // per source: acknowledge beats force, force beats line edges
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pend_d[i] = ack_mask_i[i]   ? 1'b0 :
                       force_mask_i[i] ? force_val_i[i] :
                       rise[i]         ? 1'b1 :
                       fall[i]         ? 1'b0 : pend_o[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_o <= '0;
    end else begin
      line_q <= line_i;
      pend_o <= pend_d;
    end
  end

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & ~force_mask_i & ~ack_mask_i)) |=>
    ((pend_o & $past(rise & ~force_mask_i & ~ack_mask_i)) == $past(rise & ~force_mask_i & ~ack_mask_i)));

  // R2
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fall & ~force_mask_i)) |=> ((pend_o & $past(fall & ~force_mask_i)) == '0));
endmodule

// File: rtl/irqc_prio_gate.sv
module irqc_prio_gate #(
  parameter int unsigned N  = 64,
  parameter int unsigned PW = 4,
  parameter int unsigned LW = 5
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [LW-1:0]   level_i,
  output logic            req_o
);
  localparam logic [LW-1:0] OPEN_LEVEL = '1;

  logic [N-1:0] above;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign above[i] = {{(LW-PW){1'b0}}, prio_i[i*PW +: PW]} > level_i;
  end

  assign req_o = (level_i == OPEN_LEVEL) ? (|cand_i) : (|(cand_i & above));
endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter int unsigned DW      = BUS_W,
  parameter int unsigned PW      = PRI_W,
  parameter int unsigned LW      = LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               fast_irq,
  output logic               normal_irq
);
  localparam int unsigned IW         = $clog2(NUM_SRC);
  localparam int unsigned HALF       = NUM_SRC / 2;
  localparam int unsigned PRIO_WORDS = NUM_SRC * PW / DW;
  localparam int unsigned PSW        = $clog2(PRIO_WORDS);
  localparam int unsigned VEC_PAD    = DW / 2 - IW;

  logic [DW-1:0]                    ctrl_q;
  logic [LW-1:0]                    level_q;
  logic [NUM_SRC-1:0]               en_q;
  logic [NUM_SRC-1:0]               type_q;
  logic [PRIO_WORDS-1:0][DW-1:0]    prio_q;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] norm_cand;
  logic [NUM_SRC-1:0] fast_cand;
  logic [NUM_SRC-1:0] force_mask;
  logic [NUM_SRC-1:0] force_val;
  logic [NUM_SRC-1:0] ack_mask;
  logic               n_found;
  logic               f_found;
  logic [IW-1:0]      n_idx;
  logic [IW-1:0]      f_idx;
  logic               n_req;
  logic               pri_hit;
  logic [PSW-1:0]     pri_slot;
  logic               idx_ok;

  assign norm_cand = pend & en_q & ~type_q;
  assign fast_cand = pend & en_q & type_q;
  assign pri_hit   = (bus_addr >= OFS_PRI_FIRST) && (bus_addr <= OFS_PRI_LAST);
  assign pri_slot  = PSW'(OFS_PRI_LAST - bus_addr);
  assign idx_ok    = bus_wdata < DW'(NUM_SRC);

  irqc_src_bank #(.N(NUM_SRC)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (irq_lines),
    .force_mask_i (force_mask),
    .force_val_i  (force_val),
    .ack_mask_i   (ack_mask),
    .pend_o       (pend)
  );

  irqc_first_set #(.N(NUM_SRC), .IW(IW)) u_first_norm (
    .vec_i   (norm_cand),
    .found_o (n_found),
    .idx_o   (n_idx)
  );

  irqc_first_set #(.N(NUM_SRC), .IW(IW)) u_first_fast (
    .vec_i   (fast_cand),
    .found_o (f_found),
    .idx_o   (f_idx)
  );

  irqc_prio_gate #(.N(NUM_SRC), .PW(PW), .LW(LW)) u_gate (
    .cand_i  (norm_cand),
    .prio_i  (prio_q),
    .level_i (level_q),
    .req_o   (n_req)
  );

  // force writes replace one half of the pending vector
  always_comb begin
    force_mask = '0;
    force_val  = '0;
    if (bus_wr && bus_addr == OFS_FORCE_HI) begin
      force_mask[NUM_SRC-1:HALF] = '1;
      force_val[NUM_SRC-1:HALF]  = bus_wdata;
    end
    if (bus_wr && bus_addr == OFS_FORCE_LO) begin
      force_mask[HALF-1:0] = '1;
      force_val[HALF-1:0]  = bus_wdata;
    end
  end

  // vector reads acknowledge the reported source
  always_comb begin
    ack_mask = '0;
    if (bus_rd && bus_addr == OFS_VEC_NORM && n_found) ack_mask[n_idx] = 1'b1;
    if (bus_rd && bus_addr == OFS_VEC_FAST && f_found) ack_mask[f_idx] = 1'b1;
  end

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      level_q <= '1;
      en_q    <= '0;
      type_q  <= '0;
      prio_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL:    ctrl_q <= bus_wdata;
        OFS_LEVEL:   level_q <= bus_wdata[LW-1:0];
        OFS_EN_SET:  if (idx_ok) en_q[bus_wdata[IW-1:0]] <= 1'b1;
        OFS_EN_CLR:  if (idx_ok) en_q[bus_wdata[IW-1:0]] <= 1'b0;
        OFS_EN_HI:   en_q[NUM_SRC-1:HALF] <= bus_wdata;
        OFS_EN_LO:   en_q[HALF-1:0] <= bus_wdata;
        OFS_TYPE_HI: type_q[NUM_SRC-1:HALF] <= bus_wdata;
        OFS_TYPE_LO: type_q[HALF-1:0] <= bus_wdata;
        default:     if (pri_hit) prio_q[pri_slot] <= bus_wdata;
      endcase
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:     bus_rdata = ctrl_q;
      OFS_LEVEL:    bus_rdata = {{(DW-LW){1'b0}}, level_q};
      OFS_EN_HI:    bus_rdata = en_q[NUM_SRC-1:HALF];
      OFS_EN_LO:    bus_rdata = en_q[HALF-1:0];
      OFS_TYPE_HI:  bus_rdata = type_q[NUM_SRC-1:HALF];
      OFS_TYPE_LO:  bus_rdata = type_q[HALF-1:0];
      OFS_VEC_NORM: bus_rdata = n_found ? {{VEC_PAD{1'b0}}, n_idx, {(DW/2){1'b0}}} : NO_VECTOR;
      OFS_VEC_FAST: bus_rdata = f_found ? {{VEC_PAD{1'b0}}, f_idx, {(DW/2){1'b0}}} : NO_VECTOR;
      OFS_RAW_HI:   bus_rdata = pend[NUM_SRC-1:HALF];
      OFS_RAW_LO:   bus_rdata = pend[HALF-1:0];
      OFS_NPEND_HI: bus_rdata = norm_cand[NUM_SRC-1:HALF];
      OFS_NPEND_LO: bus_rdata = norm_cand[HALF-1:0];
      OFS_FPEND_HI: bus_rdata = fast_cand[NUM_SRC-1:HALF];
      OFS_FPEND_LO: bus_rdata = fast_cand[HALF-1:0];
      OFS_TBL_FIRST: bus_rdata = IDLE_MARKER;
      default:      if (pri_hit) bus_rdata = prio_q[pri_slot];
    endcase
  end

  // registered request outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_irq   <= 1'b0;
      normal_irq <= 1'b0;
    end else begin
      fast_irq   <= |fast_cand;
      normal_irq <= n_req;
    end
  end

  // R3
  fast_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fast_cand) |=> fast_irq);

  // R5
  normal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|norm_cand)) |=> !normal_irq);

  // R6
  level_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_LEVEL) |-> (bus_rdata[DW-1:LW] == '0));

  // R7
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET && idx_ok) |=> en_q[$past(bus_wdata[IW-1:0])]);

  // R9
  lowest_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_found |-> (norm_cand[n_idx] &&
                 ((norm_cand & ((NUM_SRC'(1) << n_idx) - NUM_SRC'(1))) == '0)));

  // R9
  vec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_VEC_NORM && n_found) |=> !pend[$past(n_idx)]);

  // R12
  table_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= OFS_TBL_FIRST && bus_addr <= OFS_TBL_LAST) |=>
    ($stable(en_q) && $stable(type_q) && $stable(ctrl_q) && $stable(level_q)));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_irq;
  logic        normal_irq;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fast_irq(fast_irq), .normal_irq(normal_irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [63:0]      m_pend = '0, m_en = '0, m_type = '0, m_lineq = '0;
  logic [31:0]      m_ctrl = '0;
  logic [4:0]       m_lvl = 5'h1F;
  logic [7:0][31:0] m_prio = '0;
  logic             m_fast = 1'b0, m_norm = 1'b0;
  string            m_norm_tag = "R4";
  logic [63:0]      lines = '0;

  function automatic int first_of(logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [3:0] prio_of(int n);
    logic [31:0] w;
    w = m_prio[n / 8] >> (4 * (n % 8));
    return w[3:0];
  endfunction

  function automatic logic norm_req();
    logic [63:0] c;
    c = m_pend & m_en & ~m_type;
    if (m_lvl == 5'h1F) return |c;
    for (int i = 0; i < 64; i++)
      if (c[i] && {1'b0, prio_of(i)} > m_lvl) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] vec_word(logic [63:0] c);
    int k;
    k = first_of(c);
    if (k < 0) return 32'hFFFF_0000;
    return k << 16;
  endfunction

  function automatic logic [31:0] exp_read(logic [9:0] a);
    logic [63:0] nc, fc;
    nc = m_pend & m_en & ~m_type;
    fc = m_pend & m_en & m_type;
    case (a)
      10'd0:  return m_ctrl;
      10'd1:  return {27'd0, m_lvl};
      10'd4:  return m_en[63:32];
      10'd5:  return m_en[31:0];
      10'd6:  return m_type[63:32];
      10'd7:  return m_type[31:0];
      10'd16: return vec_word(nc);
      10'd17: return vec_word(fc);
      10'd18: return m_pend[63:32];
      10'd19: return m_pend[31:0];
      10'd22: return nc[63:32];
      10'd23: return nc[31:0];
      10'd24: return fc[63:32];
      10'd25: return fc[31:0];
      10'h40: return 32'd4;
      default: begin
        if (a >= 10'd8 && a <= 10'd15) return m_prio[15 - a];
        return 32'd0;
      end
    endcase
  endfunction

  function automatic string req_of(logic [9:0] a);
    if (a == 0) return "R13";
    if (a == 1) return "R6";
    if (a >= 2 && a <= 7) return "R7";
    if (a >= 8 && a <= 15) return "R8";
    if (a == 16 || a == 17) return "R9";
    if (a == 18 || a == 19) return "R2";
    if (a == 20 || a == 21) return "R10";
    if (a >= 22 && a <= 25) return "R11";
    return "R12";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(logic wr, logic rd, logic [9:0] a, logic [31:0] d, logic [63:0] l);
    logic [63:0] np, rise, fall;
    int k;
    m_fast = |(m_pend & m_en & m_type);
    m_norm = norm_req();
    m_norm_tag = (m_lvl == 5'h1F) ? "R4" : "R5";
    rise = l & ~m_lineq;
    fall = ~l & m_lineq;
    np = (m_pend | rise) & ~fall;
    if (wr && a == 10'd20) np[63:32] = d;
    if (wr && a == 10'd21) np[31:0] = d;
    if (rd && a == 10'd16) begin
      k = first_of(m_pend & m_en & ~m_type);
      if (k >= 0) np[k] = 1'b0;
    end
    if (rd && a == 10'd17) begin
      k = first_of(m_pend & m_en & m_type);
      if (k >= 0) np[k] = 1'b0;
    end
    if (wr) begin
      case (a)
        10'd0: m_ctrl = d;
        10'd1: m_lvl = d[4:0];
        10'd2: if (d < 64) m_en[d[5:0]] = 1'b1;
        10'd3: if (d < 64) m_en[d[5:0]] = 1'b0;
        10'd4: m_en[63:32] = d;
        10'd5: m_en[31:0] = d;
        10'd6: m_type[63:32] = d;
        10'd7: m_type[31:0] = d;
        default: if (a >= 10'd8 && a <= 10'd15) m_prio[15 - a] = d;
      endcase
    end
    m_lineq = l;
    m_pend = np;
  endtask

  task automatic step(logic wr, logic rd, logic [9:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; irq_lines = lines;
    #1;
    if (rd) check((tag != "") ? tag : req_of(a), bus_rdata, exp_read(a));
    check((tag != "") ? tag : "R3", {31'd0, fast_irq}, {31'd0, m_fast});
    check((tag != "") ? tag : m_norm_tag, {31'd0, normal_irq}, {31'd0, m_norm});
    @(posedge clk);
    model_update(wr, rd, a, d, lines);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    step(1'b1, 1'b0, a, d, "");
  endtask
  task automatic rd(logic [9:0] a, string tag = "");
    step(1'b0, 1'b1, a, 32'd0, tag);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 10'd0, 32'd0, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(10'd1, "R1");
    rd(10'd5, "R1");
    rd(10'd16, "R1");
    rd(10'd17, "R1");
    rd(10'd19, "R1");
    // R8 priority layout: source 1 prio 3, source 60 prio 9
    wr(10'd15, 32'h0000_0030);
    wr(10'd8, 32'h0009_0000);
    rd(10'd15); rd(10'd8);
    // R7 enable by number, R4/R5 threshold
    wr(10'd2, 32'd1);
    wr(10'd2, 32'd64);
    rd(10'd4); rd(10'd5); rd(10'd2); rd(10'd3);
    lines[1] = 1'b1;
    wr(10'd1, 32'd2);
    idle(3);
    wr(10'd1, 32'd3);
    idle(2);
    wr(10'd1, 32'hFFFF_FFFF);
    rd(10'd1);
    idle(2);
    // R9 normal vector read acknowledges
    rd(10'd16);
    idle(2);
    rd(10'd16);
    lines[1] = 1'b0;
    idle(2);
    // R3 fast class
    wr(10'd7, 32'h0000_0020);
    wr(10'd2, 32'd5);
    lines[5] = 1'b1;
    idle(3);
    rd(10'd17);
    idle(2);
    lines[5] = 1'b0;
    wr(10'd3, 32'd5);
    // R10 / R11 force and masked views
    wr(10'd4, 32'hF0F0_0000);
    wr(10'd20, 32'hFF00_FF00);
    wr(10'd21, 32'h0000_0021);
    rd(10'd18); rd(10'd19); rd(10'd20); rd(10'd21);
    rd(10'd22); rd(10'd23); rd(10'd24); rd(10'd25);
    rd(10'd16);
    // R13 control and R12 ignored writes
    wr(10'd0, 32'hA5A5_5A5A);
    rd(10'd0);
    wr(10'h40, 32'hFFFF_FFFF);
    wr(10'hBF, 32'hFFFF_FFFF);
    wr(10'd16, 32'h0);
    wr(10'd18, 32'hFFFF_FFFF);
    wr(10'd23, 32'hFFFF_FFFF);
    wr(10'h30, 32'hFFFF_FFFF);
    rd(10'd18); rd(10'd19); rd(10'd0); rd(10'd5);
    rd(10'h40); rd(10'h30); rd(10'h1FF);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [9:0] a;
      logic [31:0] d;
      if ($urandom % 4 == 0) lines[$urandom % 64] = ~lines[$urandom % 64];
      r = $urandom % 100;
      if (r < 35) begin
        a = 10'($urandom % 27);
        if ($urandom % 10 == 0) a = 10'h40;
        rd(a);
      end else if (r < 75) begin
        case ($urandom % 8)
          0: begin a = 10'd2; d = $urandom % 70; end
          1: begin a = 10'd3; d = $urandom % 70; end
          2: begin a = 10'd1; d = ($urandom % 8 == 0) ? 32'h1F : $urandom % 16; end
          3: begin a = 10'(8 + $urandom % 8); d = $urandom; end
          4: begin a = 10'(6 + $urandom % 2); d = $urandom; end
          5: begin a = 10'(20 + $urandom % 2); d = $urandom & $urandom; end
          6: begin a = 10'(4 + $urandom % 2); d = $urandom; end
          default: begin a = 10'($urandom % 256); d = $urandom; end
        endcase
        wr(a, d);
      end else begin
        idle(1);
      end
    end
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule